// File: doc/BRIEF.md
# Vertical Line-Skip Downscaler (Fractional Step)

This block decides which source lines of a video overlay are fetched when the overlay is shrunk vertically. It holds a fractional phase that grows by a programmed step after every output line. Each output line moves the source pointer forward by one line. When the phase addition overflows, the pointer moves forward by one further line. As a result, ratios between 1:1 and 2:1 are reached by dropping whole source lines, with no filtering.

A frame starts with a vertical retrace pulse. The retrace returns the pointer to line 0 and clears the phase. Because the carry is only applied after a line has been issued, line 0 is always issued and can never be skipped. Each pulse of the line-advance strobe consumes the index shown on `line_idx`. The pointer stops at the source line count, and `frame_done` then marks that the frame has run out of source lines.

The step value is written through one 32-bit configuration word. That word also stores two auxiliary fields, which the block only keeps and reads back. The remaining bits of the word are reserved.

Top module: `vline_skip_dda`

## Requirements
- R1: Reset, and every cycle with `vretrace` high, set `line_idx` to 0 and clear the phase, so the first index issued in a frame is always 0.
- R2: While `ds_en` is low, each accepted line advance raises `line_idx` by exactly one, and the phase is left unchanged.
- R3: While `ds_en` is high, each accepted advance adds the step to the 14-bit phase. The new phase is the low 14 bits of the sum. `line_idx` rises by 1 plus the carry out of bit 14.
- R4: With a step of zero and `ds_en` high, every source line is issued in order.
- R5: The step is an unsigned 14-bit fraction written to bits 31:18 of `cfg_wdata` when `cfg_we` is high. The word resets to zero, and `cfg_rdata` returns the stored value.
- R6: Bits 17:16 and 14:12 of the configuration word always read as zero. Writing ones to them has no effect.
- R7: Bit 15 and bits 11:0 of the configuration word are stored and read back unchanged. They have no effect on the line sequence.
- R8: A step written during a frame is used only from the next `vretrace` onward. The frame in progress keeps the step it started with.
- R9: `line_idx` never exceeds `src_lines`. It saturates there, and `frame_done` is high exactly while `line_idx` equals or exceeds `src_lines`. Line advances are ignored while `frame_done` is high.
- R10: No accepted advance moves `line_idx` forward by more than two lines.
- R11: When `vretrace` and `line_advance` are high in the same cycle, the retrace wins and `line_idx` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to write (step in 31:18) |
| cfg_rdata | output | 32 | Stored configuration word, reserved bits zero |
| ds_en | input | 1 | Downscale enable; low gives 1:1 line order |
| src_lines | input | LINE_W | Number of source lines in the frame |
| vretrace | input | 1 | Vertical retrace, starts a new frame |
| line_advance | input | 1 | Consume the current index and move to the next |
| line_idx | output | LINE_W | Source line index to send downstream |
| frame_done | output | 1 | All source lines of the frame have been passed |

## Verification
The bench sweeps the whole 14-bit step range in strides and includes the extreme values 0 and 0x3FFF, with `ds_en` both high and low. For every line it compares the index against an arithmetic model.

The sweep targets specific failure modes:
- A design that took the carry before issuing the line would skip line 0.
- A design that kept the phase across retrace would shift the skip pattern in the second frame.
- A step that goes live in mid-frame is caught by rewriting the step partway through a frame.
- A pointer that does not saturate would run past the source count on a skip at the last line.

Writing all ones to the configuration word exposes reserved bits that are stored. A retrace given together with an advance catches a priority that is the wrong way round.

// File: rtl/vls_pkg.sv
package vls_pkg;

   localparam int unsigned CFG_W     = 32;
   localparam int unsigned STEP_W    = 14;
   localparam int unsigned STEP_LSB  = CFG_W - STEP_W;
   localparam int unsigned AUX_EN_B  = 15;
   localparam int unsigned AUX_VAL_W = 12;

   localparam logic [CFG_W-1:0] STEP_MASK = {{STEP_W{1'b1}}, {STEP_LSB{1'b0}}};
   localparam logic [CFG_W-1:0] AUXEN_MASK = CFG_W'(1) << AUX_EN_B;
   localparam logic [CFG_W-1:0] AUXV_MASK  = CFG_W'((1 << AUX_VAL_W) - 1);
   localparam logic [CFG_W-1:0] KEEP_MASK  = STEP_MASK | AUXEN_MASK | AUXV_MASK;

   typedef logic [STEP_W-1:0] step_t;

   typedef struct packed {
      step_t                 step;
      logic                  aux_en;
      logic [AUX_VAL_W-1:0]  aux_val;
   } cfg_t;

   function automatic cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
      cfg_t c;
      c.step    = w[CFG_W-1:STEP_LSB];
      c.aux_en  = w[AUX_EN_B];
      c.aux_val = w[AUX_VAL_W-1:0];
      return c;
   endfunction

   function automatic logic [CFG_W-1:0] cfg_pack(input cfg_t c);
      logic [CFG_W-1:0] w;
      w = '0;
      w[CFG_W-1:STEP_LSB]  = c.step;
      w[AUX_EN_B]          = c.aux_en;
      w[AUX_VAL_W-1:0]     = c.aux_val;
      return w;
   endfunction

endpackage

// File: rtl/vls_cfg_word.sv
module vls_cfg_word
   import vls_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] rdata,
   output step_t            step
);

   cfg_t cfg_q;

   initial begin
      assert (STEP_LSB + STEP_W == CFG_W) else $error("step field must end at the top bit");
      assert (AUX_EN_B < STEP_LSB && AUX_VAL_W <= AUX_EN_B)
         else $error("auxiliary fields overlap the step field");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (we) begin
         cfg_q <= cfg_unpack(wdata);
      end
   end

   assign rdata = cfg_pack(cfg_q);
   assign step  = cfg_q.step;

   AST_STEP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> step == $past(wdata[CFG_W-1:STEP_LSB])); // R5

   AST_RSVD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> rdata == ($past(wdata) & KEEP_MASK)); // R6

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(rdata)); // R7

endmodule

// File: rtl/vls_phase_acc.sv
module vls_phase_acc
   import vls_pkg::*;
#(
   parameter bit LATCH_AT_RETRACE = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  vretrace,
   input  logic  adv,
   input  logic  ds_en,
   input  step_t step_in,
   output logic  carry
);

   localparam int unsigned SUM_W = STEP_W + 1;

   step_t            step_act;
   step_t            phase_q;
   logic [SUM_W-1:0] sum;

   generate
      if (LATCH_AT_RETRACE) begin : g_shadow
         step_t step_sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               step_sh_q <= '0;
            end else if (vretrace) begin
               step_sh_q <= step_in;
            end
         end
         assign step_act = step_sh_q;

         AST_STEP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            !vretrace |=> $stable(step_act)); // R8
      end else begin : g_live
         assign step_act = step_in;
      end
   endgenerate

   assign sum   = {1'b0, phase_q} + {1'b0, step_act};
   assign carry = ds_en & sum[STEP_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (vretrace) begin
         phase_q <= '0;
      end else if (adv && ds_en) begin
         phase_q <= sum[STEP_W-1:0];
      end
   end

   AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      vretrace |=> phase_q == '0); // R1

   AST_PHASE_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ds_en && !vretrace) |=> $stable(phase_q)); // R2

   AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ds_en && !vretrace && !carry && $stable(step_act)) |=>
         phase_q >= $past(phase_q)); // R3

endmodule

// File: rtl/vls_line_ptr.sv
module vls_line_ptr #(
   parameter int unsigned LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vretrace,
   input  logic              adv,
   input  logic              carry,
   input  logic [LINE_W-1:0] limit,
   output logic [LINE_W-1:0] ptr,
   output logic              done
);

   localparam int unsigned EXT_W = LINE_W + 1;

   logic [LINE_W-1:0] ptr_q;
   logic [EXT_W-1:0]  ptr_inc;
   logic [LINE_W-1:0] ptr_nxt;

   assign ptr_inc = {1'b0, ptr_q} + EXT_W'(1) + EXT_W'(carry);
   assign ptr_nxt = (ptr_inc >= {1'b0, limit}) ? limit : ptr_inc[LINE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (vretrace) begin
         ptr_q <= '0;
      end else if (adv) begin
         ptr_q <= ptr_nxt;
      end
   end

   assign ptr  = ptr_q;
   assign done = (ptr_q >= limit);

   AST_PTR_RETRACE: assert property (@(posedge clk) disable iff (!rst_n)
      vretrace |=> ptr == '0); // R1

   AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !vretrace) |=> $stable(ptr)); // R9

endmodule

// File: rtl/vline_skip_dda.sv
module vline_skip_dda
   import vls_pkg::*;
#(
   parameter int unsigned LINE_W           = 11,
   parameter bit          LATCH_AT_RETRACE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              ds_en,
   input  logic [LINE_W-1:0] src_lines,
   input  logic              vretrace,
   input  logic              line_advance,
   output logic [LINE_W-1:0] line_idx,
   output logic              frame_done
);

   localparam int unsigned MAX_LINES = (1 << LINE_W) - 1;

   initial begin
      assert (LINE_W >= 2 && LINE_W <= 16) else $error("LINE_W out of range 2..16");
      assert (CFG_W == 32) else $error("configuration word must be 32 bits");
      assert (MAX_LINES >= 3) else $error("line space too small");
   end

   step_t step_reg;
   logic  carry;
   logic  adv_ok;

   vls_cfg_word i_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .step  (step_reg)
   );

   assign adv_ok = line_advance & ~frame_done & ~vretrace;

   vls_phase_acc #(
      .LATCH_AT_RETRACE (LATCH_AT_RETRACE)
   ) i_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .vretrace (vretrace),
      .adv      (adv_ok),
      .ds_en    (ds_en),
      .step_in  (step_reg),
      .carry    (carry)
   );

   vls_line_ptr #(
      .LINE_W (LINE_W)
   ) i_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .vretrace (vretrace),
      .adv      (adv_ok),
      .carry    (carry),
      .limit    (src_lines),
      .ptr      (line_idx),
      .done     (frame_done)
   );

   AST_FIRST_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (vretrace && line_advance) |=> line_idx == '0); // R11

   AST_ADV_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (line_advance && !frame_done && !vretrace && $stable(src_lines)) |=>
         ((line_idx == $past(line_idx) + LINE_W'(1)) ||
          (line_idx == $past(line_idx) + LINE_W'(2)) ||
          (line_idx == src_lines))); // R10

   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      (line_advance && !vretrace && $stable(src_lines) && line_idx <= src_lines) |=>
         line_idx <= src_lines); // R9

   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (line_advance && !ds_en && !frame_done && !vretrace && $stable(src_lines)) |=>
         ((line_idx == $past(line_idx) + LINE_W'(1)) || (line_idx == src_lines))); // R2

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !vretrace && $stable(src_lines)) |=> $stable(line_idx)); // R9

endmodule

// File: tb/test_vline_skip_dda.sv
module test_vline_skip_dda;

   localparam int CLK_PERIOD = 10;
   localparam int LW         = 11;
   localparam int NLINES     = 37;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          ds_en = 1'b0;
   logic [LW-1:0] src_lines = LW'(NLINES);
   logic          vretrace = 1'b0;
   logic          line_advance = 1'b0;
   logic [LW-1:0] line_idx;
   logic          frame_done;

   int n_vec = 0;
   int n_bad = 0;

   int m_ptr = 0;
   int m_phase = 0;
   int m_step_reg = 0;
   int m_step_act = 0;
   bit m_en = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vline_skip_dda #(.LINE_W(LW)) i_vline_skip_dda (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_wdata    (cfg_wdata),
      .cfg_rdata    (cfg_rdata),
      .ds_en        (ds_en),
      .src_lines    (src_lines),
      .vretrace     (vretrace),
      .line_advance (line_advance),
      .line_idx     (line_idx),
      .frame_done   (frame_done)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [31:0] w);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = w;
      @(negedge clk);
      cfg_we = 1'b0;
      m_step_reg = int'(w[31:18]);
   endtask

   task automatic retrace(input bit with_adv);
      @(negedge clk);
      vretrace = 1'b1;
      line_advance = with_adv;
      @(negedge clk);
      vretrace = 1'b0;
      line_advance = 1'b0;
      m_ptr = 0;
      m_phase = 0;
      m_step_act = m_step_reg;
   endtask

   // checks current index, then consumes it
   task automatic one_line(input string req);
      int sum;
      int c;
      @(negedge clk);
      chk(req, line_idx, m_ptr);
      chk("R9", frame_done, (m_ptr >= NLINES) ? 1 : 0);
      line_advance = 1'b1;
      @(negedge clk);
      line_advance = 1'b0;
      if (m_ptr < NLINES) begin
         c = 0;
         if (m_en) begin
            sum = m_phase + m_step_act;
            c = sum >> 14;
            m_phase = sum & 16'h3FFF;
         end
         m_ptr = m_ptr + 1 + c;
         if (m_ptr > NLINES) m_ptr = NLINES;
      end
   endtask

   task automatic run_frame(input string req, input int max_lines);
      for (int i = 0; i < max_lines; i++) begin
         one_line(req);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R5", cfg_rdata, 0);
      chk("R1", line_idx, 0);
      chk("R9", frame_done, 0);
      rst_n = 1'b1;

      // register field checks
      wr_cfg(32'hFFFF_FFFF);
      chk("R6", cfg_rdata, 32'hFFFC_8FFF);
      wr_cfg(32'h0003_7000);
      chk("R6", cfg_rdata, 0);
      wr_cfg(32'h1234_8ABC);
      chk("R5", cfg_rdata[31:18], 32'h1234_8ABC >> 18);
      chk("R7", cfg_rdata[15:0], 16'h8ABC);

      // auxiliary fields with zero step: pure pass-through
      wr_cfg(32'h0000_8FFF);
      ds_en = 1'b1; m_en = 1;
      retrace(0);
      for (int i = 0; i < NLINES + 3; i++) begin
         one_line("R7");
      end

      // zero step with enable: 1:1
      wr_cfg(32'h0);
      retrace(0);
      for (int i = 0; i < NLINES; i++) begin
         @(negedge clk);
         chk("R4", line_idx, i);
         line_advance = 1'b1;
         @(negedge clk);
         line_advance = 1'b0;
      end
      @(negedge clk);
      chk("R9", frame_done, 1);
      m_ptr = NLINES;

      // sweep of step values, enable toggled
      for (int k = 0; k <= 16383 + 29; k += 29) begin
         int s;
         s = (k > 16383) ? 16383 : k;
         m_en = ((k / 29) % 5) != 4;
         ds_en = m_en;
         wr_cfg(32'(s) << 18);
         retrace(0);
         run_frame(m_en ? "R3" : "R2", NLINES + 2);
      end

      // largest step: every second line, no more than two per advance
      m_en = 1; ds_en = 1'b1;
      wr_cfg(32'h3FFF << 18);
      retrace(0);
      run_frame("R10", NLINES + 1);

      // mid-frame step change must wait for retrace
      wr_cfg(32'h1000 << 18);
      retrace(0);
      run_frame("R8", 6);
      wr_cfg(32'h3F00 << 18);
      run_frame("R8", 8);
      retrace(0);
      run_frame("R8", 10);

      // second frame after partial one: phase cleared
      wr_cfg(32'h2AAA << 18);
      retrace(0);
      run_frame("R1", 5);
      retrace(0);
      run_frame("R1", 12);

      // retrace and advance together: retrace wins
      run_frame("R11", 3);
      retrace(1);
      @(negedge clk);
      chk("R11", line_idx, 0);
      run_frame("R11", 4);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule